// File: doc/BRIEF.md
# Speedup-L Output Acceptance Arbiter

This block is the per-slot arbiter of a switch that keeps buffers at both its inputs and its outputs. Each output buffer can write up to L cells per slot, where L is a compile-time constant with 1 < L < N. At the start of every slot the arbiter reads the head-of-line request of each of the N inputs: a valid bit and a destination output number. For every output it picks up to L of the inputs that target it and raises their grant bits.

Inputs that are not picked receive no grant. They keep their head cell and present it again in a later slot, so no cell is dropped when an output is oversubscribed. Each output reports how many free entries its FIFO has. An output never accepts more cells than it has free entries, and this holds back traffic when the output is full.

Within an output, the search starts at a rotating priority pointer. After a slot in which that output granted anything, the pointer moves to the input just past the last one granted. This spreads service fairly across the inputs. The results are registered and appear one clock after the slot strobe. They are a grant vector indexed by input and a count of accepted cells for each output.

Top module: `spd_accept_arb`

## Requirements
- R1: After reset, `grant` and every `acceptCnt` field are 0 and `gntValid` is 0. Every output's priority pointer starts at input 0.
- R2: A high `slotStart` on one clock edge produces `grant`, `acceptCnt` and a one-cycle `gntValid` pulse on that same edge. `grant` and `acceptCnt` then hold until the next slot.
- R3: No `acceptCnt` field ever exceeds L.
- R4: For each output j, the number of cells granted equals the smaller of its capacity and the number of valid requests for j. Requests beyond the capacity get no grant, so the inputs keep them.
- R5: Output j grants in ascending input order, wrapping from N-1 to 0. It starts at its pointer and takes the first eligible requesters.
- R6: After a slot in which output j granted at least one input, its pointer becomes (last granted input + 1) mod N. After a slot in which it granted nothing, the pointer is unchanged.
- R7: The capacity of output j is min(L, free_j). free_j is field j of `outFree`, at bits [j*FW +: FW]. When free_j is 0, output j grants nothing.
- R8: An input is granted only if its `reqValid` bit was set, and only by the output in its destination field. Field i of `reqDest` is at bits [i*DW +: DW], with DW = clog2(N). The `acceptCnt` field j, at bits [j*CW +: CW] with CW = clog2(L+1), equals the number of granted inputs whose destination is j.
- R9: While `slotStart` is low, `grant`, `acceptCnt` and all pointers keep their values, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStart | input | 1 | Evaluate the arbitration for this slot |
| reqValid | input | N | Head-of-line cell present, one bit per input |
| reqDest | input | N*DW | Destination output of each input's head cell |
| outFree | input | N*FW | Free entries of each output FIFO |
| grant | output | N | Granted inputs of the last slot |
| acceptCnt | output | N*CW | Cells accepted by each output in the last slot |
| gntValid | output | 1 | One-cycle pulse marking fresh results |

## Verification
Every result of a slot is registered on the edge where `slotStart` is high, so grants, counts and the valid pulse are all due one clock after the strobe. The bench raises the strobe for exactly one cycle. It reads the outputs on the next falling edge and again one cycle later, to see that the pulse has ended and the values are held. Pointer motion cannot be seen directly. Each slot's expected grants are therefore derived from the pointer positions left by the preceding vectors, starting from a known reset. Idle cycles are checked the same way: the outputs must not move during them, and the next slot must show pointers that did not move either.

// File: rtl/spd_arb_pkg.sv
package spd_arb_pkg;

  // Strobes from the control part to the datapath.
  typedef struct packed {
    logic loadResult;  // capture grants and counts of this slot
    logic pulseValid;  // raise the result-valid flag for one cycle
  } arbStrobe_t;

  function automatic int minOf(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/spd_arb_slice.sv
// Arbitration for one output: rotating search from the pointer, limited by
// min(L, free entries).
module spd_arb_slice #(
  parameter int N_IN   = 8,
  parameter int L_SPD  = 2,
  parameter int FREE_W = 4,
  parameter int OUT_ID = 0,
  localparam int IDX_W = $clog2(N_IN),
  localparam int CNT_W = $clog2(L_SPD + 1)
) (
  input  logic [IDX_W-1:0]       ptr,
  input  logic [N_IN-1:0]        reqValid,
  input  logic [N_IN*IDX_W-1:0]  reqDest,
  input  logic [FREE_W-1:0]      freeSlots,
  output logic [N_IN-1:0]        gntVec,
  output logic [CNT_W-1:0]       acceptNum,
  output logic                   anyGnt,
  output logic [IDX_W-1:0]       lastIdx
);

  logic [CNT_W-1:0] capacity;
  logic [N_IN-1:0]  wantsMe;

  always_comb begin
    if (int'(freeSlots) < L_SPD) capacity = CNT_W'(freeSlots);
    else                         capacity = CNT_W'(L_SPD);
  end

  // Which inputs target this output.
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      wantsMe[i] = reqValid[i] && (reqDest[i*IDX_W +: IDX_W] == IDX_W'(OUT_ID));
    end
  end

  always_comb begin
    int idx;
    logic [CNT_W-1:0] taken;
    gntVec  = '0;
    taken   = '0;
    anyGnt  = 1'b0;
    lastIdx = ptr;
    for (int k = 0; k < N_IN; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N_IN) idx = idx - N_IN;
      if (wantsMe[idx] && (taken < capacity)) begin
        gntVec[idx] = 1'b1;
        taken       = taken + CNT_W'(1);
        anyGnt      = 1'b1;
        lastIdx     = IDX_W'(idx);
      end
    end
    acceptNum = taken;
  end

endmodule

// File: rtl/spd_arb_ctrl.sv
// Control: slot strobes and the per-output rotating priority pointers.
module spd_arb_ctrl
  import spd_arb_pkg::*;
#(
  parameter int N_IN   = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotStart,
  input  logic [N_IN-1:0]        anyGnt,
  input  logic [N_IN*IDX_W-1:0]  lastIdx,
  output arbStrobe_t             strobe,
  output logic [N_IN*IDX_W-1:0]  ptrFlat
);

  always_comb begin
    strobe.loadResult = slotStart;
    strobe.pulseValid = slotStart;
  end

  for (genvar j = 0; j < N_IN; j++) begin : g_ptr
    logic [IDX_W-1:0] ptrQ;
    logic [IDX_W-1:0] lastJ;
    logic [IDX_W-1:0] nextPtr;

    assign lastJ = lastIdx[j*IDX_W +: IDX_W];

    always_comb begin
      if (int'(lastJ) == N_IN - 1) nextPtr = '0;
      else                         nextPtr = lastJ + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
      if (!rstN)                       ptrQ <= '0;
      else if (slotStart && anyGnt[j]) ptrQ <= nextPtr;
    end

    assign ptrFlat[j*IDX_W +: IDX_W] = ptrQ;
  end

endmodule

// File: rtl/spd_arb_datapath.sv
// Datapath: per-output slices, grant merge and result registers.
module spd_arb_datapath
  import spd_arb_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int L_SPD  = 2,
  parameter int FREE_W = 4,
  localparam int IDX_W = $clog2(N_IN),
  localparam int CNT_W = $clog2(L_SPD + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arbStrobe_t             strobe,
  input  logic [N_IN*IDX_W-1:0]  ptrFlat,
  input  logic [N_IN-1:0]        reqValid,
  input  logic [N_IN*IDX_W-1:0]  reqDest,
  input  logic [N_IN*FREE_W-1:0] outFree,
  output logic [N_IN-1:0]        anyGnt,
  output logic [N_IN*IDX_W-1:0]  lastIdx,
  output logic [N_IN-1:0]        grant,
  output logic [N_IN*CNT_W-1:0]  acceptCnt,
  output logic                   gntValid
);

  logic [N_IN-1:0]       gntPerOut [N_IN];
  logic [N_IN*CNT_W-1:0] cntNext;
  logic [N_IN-1:0]       grantNext;

  for (genvar j = 0; j < N_IN; j++) begin : g_slice
    spd_arb_slice #(
      .N_IN(N_IN), .L_SPD(L_SPD), .FREE_W(FREE_W), .OUT_ID(j)
    ) u_slice (
      .ptr       (ptrFlat[j*IDX_W +: IDX_W]),
      .reqValid  (reqValid),
      .reqDest   (reqDest),
      .freeSlots (outFree[j*FREE_W +: FREE_W]),
      .gntVec    (gntPerOut[j]),
      .acceptNum (cntNext[j*CNT_W +: CNT_W]),
      .anyGnt    (anyGnt[j]),
      .lastIdx   (lastIdx[j*IDX_W +: IDX_W])
    );
  end

  // Each input names one output, so at most one slice grants it.
  always_comb begin
    grantNext = '0;
    for (int j = 0; j < N_IN; j++) grantNext = grantNext | gntPerOut[j];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant     <= '0;
      acceptCnt <= '0;
      gntValid  <= 1'b0;
    end else begin
      gntValid <= strobe.pulseValid;
      if (strobe.loadResult) begin
        grant     <= grantNext;
        acceptCnt <= cntNext;
      end
    end
  end

endmodule

// File: rtl/spd_accept_arb.sv
// Thin top: control plus datapath.
module spd_accept_arb
  import spd_arb_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int L_SPD  = 2,
  parameter int FREE_W = 4,
  localparam int IDX_W = $clog2(N_IN),
  localparam int CNT_W = $clog2(L_SPD + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotStart,
  input  logic [N_IN-1:0]        reqValid,
  input  logic [N_IN*IDX_W-1:0]  reqDest,
  input  logic [N_IN*FREE_W-1:0] outFree,
  output logic [N_IN-1:0]        grant,
  output logic [N_IN*CNT_W-1:0]  acceptCnt,
  output logic                   gntValid
);

  arbStrobe_t            strobe;
  logic [N_IN*IDX_W-1:0] ptrFlat;
  logic [N_IN-1:0]       anyGnt;
  logic [N_IN*IDX_W-1:0] lastIdx;

  spd_arb_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .slotStart (slotStart),
    .anyGnt    (anyGnt),
    .lastIdx   (lastIdx),
    .strobe    (strobe),
    .ptrFlat   (ptrFlat)
  );

  spd_arb_datapath #(.N_IN(N_IN), .L_SPD(L_SPD), .FREE_W(FREE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ptrFlat   (ptrFlat),
    .reqValid  (reqValid),
    .reqDest   (reqDest),
    .outFree   (outFree),
    .anyGnt    (anyGnt),
    .lastIdx   (lastIdx),
    .grant     (grant),
    .acceptCnt (acceptCnt),
    .gntValid  (gntValid)
  );

endmodule

// File: rtl/spd_accept_arb_chk.sv
// Property checker, bound to the top.
module spd_accept_arb_chk #(
  parameter int N_IN   = 8,
  parameter int L_SPD  = 2,
  parameter int FREE_W = 4,
  localparam int IDX_W = $clog2(N_IN),
  localparam int CNT_W = $clog2(L_SPD + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   slotStart,
  input logic [N_IN-1:0]        reqValid,
  input logic [N_IN*IDX_W-1:0]  reqDest,
  input logic [N_IN*FREE_W-1:0] outFree,
  input logic [N_IN-1:0]        grant,
  input logic [N_IN*CNT_W-1:0]  acceptCnt,
  input logic                   gntValid
);

  logic [N_IN-1:0]        capReq;
  logic [N_IN*IDX_W-1:0]  capDest;
  logic [N_IN*FREE_W-1:0] capFree;
  logic                   started;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReq  <= '0;
      capDest <= '0;
      capFree <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (slotStart) begin
        capReq  <= reqValid;
        capDest <= reqDest;
        capFree <= outFree;
      end
    end
  end

  int nReq [N_IN];
  int nGnt [N_IN];

  always_comb begin
    for (int j = 0; j < N_IN; j++) begin
      nReq[j] = 0;
      nGnt[j] = 0;
      for (int i = 0; i < N_IN; i++) begin
        if (int'(capDest[i*IDX_W +: IDX_W]) == j) begin
          if (capReq[i]) nReq[j] = nReq[j] + 1;
          if (grant[i])  nGnt[j] = nGnt[j] + 1;
        end
      end
    end
  end

  AST_VALID_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (gntValid == $past(slotStart)));  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (started && !$past(slotStart)) |-> ($stable(grant) && $stable(acceptCnt)));  // R9

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |-> ((grant & ~capReq) == '0));  // R8

  for (genvar j = 0; j < N_IN; j++) begin : g_out
    AST_NO_OVER_L: assert property (@(posedge clk) disable iff (!rstN)
      int'(acceptCnt[j*CNT_W +: CNT_W]) <= L_SPD);  // R3

    AST_CNT_MATCHES_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
      gntValid |-> (int'(acceptCnt[j*CNT_W +: CNT_W]) == nGnt[j]));  // R8

    AST_FILL_TO_CAPACITY: assert property (@(posedge clk) disable iff (!rstN)
      gntValid |-> (nGnt[j] == spd_arb_pkg::minOf(
        spd_arb_pkg::minOf(L_SPD, int'(capFree[j*FREE_W +: FREE_W])), nReq[j])));  // R4

    AST_RESPECT_FREE: assert property (@(posedge clk) disable iff (!rstN)
      gntValid |-> (nGnt[j] <= int'(capFree[j*FREE_W +: FREE_W])));  // R7
  end

endmodule

bind spd_accept_arb spd_accept_arb_chk #(
  .N_IN(N_IN), .L_SPD(L_SPD), .FREE_W(FREE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotStart (slotStart),
  .reqValid  (reqValid),
  .reqDest   (reqDest),
  .outFree   (outFree),
  .grant     (grant),
  .acceptCnt (acceptCnt),
  .gntValid  (gntValid)
);

// File: tb/spd_accept_arb_tb.sv
module spd_accept_arb_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int L  = 2;
  localparam int FW = 4;
  localparam int DW = 3;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          slotStart = 1'b0;
  logic [N-1:0]  reqValid = '0;
  logic [N*DW-1:0] reqDest = '0;
  logic [N*FW-1:0] outFree = '1;
  logic [N-1:0]  grant;
  logic [N*CW-1:0] acceptCnt;
  logic          gntValid;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_accept_arb #(.N_IN(N), .L_SPD(L), .FREE_W(FW)) u_dut (
    .clk(clk), .rstN(rstN), .slotStart(slotStart),
    .reqValid(reqValid), .reqDest(reqDest), .outFree(outFree),
    .grant(grant), .acceptCnt(acceptCnt), .gntValid(gntValid)
  );

  typedef struct packed {
    logic [N-1:0]    req;
    logic [N*DW-1:0] dest;
    logic [N*FW-1:0] free;
    logic [N-1:0]    expGnt;
  } vec_t;

  // Walked from reset, so every pointer starts at input 0.
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 24'h000000, 32'hFFFFFFFF, 8'h03},  // out0 from 0: 0,1
    '{8'hFF, 24'h000000, 32'hFFFFFFFF, 8'h0C},  // out0 from 2: 2,3
    '{8'hFF, 24'hFAC688, 32'hFFFFFFFF, 8'hFF},  // i->i, ptr_j -> j+1
    '{8'hFF, 24'h000000, 32'hFFFFFFF1, 8'h02},  // out0 free=1, from 1
    '{8'hFF, 24'h000000, 32'hFFFFFFF0, 8'h00},  // out0 full
    '{8'hFF, 24'h000000, 32'hFFFFFFFF, 8'h0C},  // ptr0 still 2
    '{8'hFF, 24'hDB6B6D, 32'hFFFFFFFF, 8'h93},  // out5 from 6, out6 from 7 wraps
    '{8'h00, 24'hDB6DB6, 32'hFFFFFFFF, 8'h00},  // no requests
    '{8'h05, 24'hDB6DB6, 32'hFFFFFFFF, 8'h05}   // only valid inputs 0,2 -> out6
  };

  function automatic logic [N*CW-1:0] cntFrom(input logic [N-1:0] g,
                                              input logic [N*DW-1:0] d);
    logic [N*CW-1:0] c = '0;
    for (int i = 0; i < N; i++) begin
      if (g[i]) begin
        int o = int'(d[i*DW +: DW]);
        c[o*CW +: CW] = c[o*CW +: CW] + CW'(1);
      end
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic runSlot(input logic [N-1:0] r, input logic [N*DW-1:0] d,
                         input logic [N*FW-1:0] f);
    @(negedge clk);
    reqValid  = r;
    reqDest   = d;
    outFree   = f;
    slotStart = 1'b1;
    @(negedge clk);
    slotStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 grant", 64'(grant), 64'h0);
    chk("R1 acceptCnt", 64'(acceptCnt), 64'h0);
    chk("R1 gntValid", 64'(gntValid), 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 gntValid after release", 64'(gntValid), 64'h0);

    for (int v = 0; v < NV; v++) begin
      runSlot(VECS[v].req, VECS[v].dest, VECS[v].free);
      // R5 R6 R7 rotation, capacity and pointer history
      chk($sformatf("R5 R6 R7 grant v%0d", v), 64'(grant), 64'(VECS[v].expGnt));
      // R4 R8 counts per output
      chk($sformatf("R4 R8 acceptCnt v%0d", v), 64'(acceptCnt),
          64'(cntFrom(VECS[v].expGnt, VECS[v].dest)));
      chk($sformatf("R2 gntValid v%0d", v), 64'(gntValid), 64'h1);
      for (int j = 0; j < N; j++) begin
        if (int'(acceptCnt[j*CW +: CW]) > L)
          chk($sformatf("R3 count over L v%0d out%0d", v, j),
              64'(acceptCnt[j*CW +: CW]), 64'(L));
      end
    end

    // R2: pulse ends one cycle later, results held
    @(negedge clk);
    chk("R2 gntValid drops", 64'(gntValid), 64'h0);
    chk("R2 grant held", 64'(grant), 64'h05);

    // R9: inputs change with no slot strobe
    reqValid = 8'hFF;
    reqDest  = 24'h000000;
    outFree  = 32'h00000000;
    repeat (3) @(negedge clk);
    chk("R9 grant idle", 64'(grant), 64'h05);
    chk("R9 acceptCnt idle", 64'(acceptCnt), 64'(cntFrom(8'h05, 24'hDB6DB6)));
    chk("R9 gntValid idle", 64'(gntValid), 64'h0);

    // R6 R9: ptr6 is 3 after the last slot (last grant was input 2)
    runSlot(8'hFF, 24'hDB6DB6, 32'hFFFFFFFF);
    chk("R6 R9 pointer kept", 64'(grant), 64'h18);
    chk("R3 R4 out6 at L", 64'(acceptCnt[6*CW +: CW]), 64'(L));

    // R1: reset restores pointers to input 0
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 grant cleared", 64'(grant), 64'h0);
    rstN = 1'b1;
    runSlot(8'hFF, 24'hDB6DB6, 32'hFFFFFFFF);
    chk("R1 R5 pointer back at 0", 64'(grant), 64'h03);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule